// File: doc/BRIEF.md
# Timer/Counter with Filtered Input Capture

This block is a timer whose counter advances on every clock. It runs either as an 8-bit counter (low byte only) or as a single 16-bit counter. In the 16-bit case the two compare bytes form one 16-bit compare value. The count either runs freely and wraps at its full range, or clears after it reaches the compare value. A one-cycle compare-match output marks the cycle in which the counter equals the compare value.

An input-capture path picks one of two capture inputs and passes it through a two-flop synchronizer. An optional glitch filter can follow the synchronizer; it changes its output only after four agreeing samples. On the chosen edge, the path copies the counter into a capture register, sets a capture flag, and raises an interrupt when that interrupt is enabled. Software reaches all state through an 8-bit register port with a 3-bit address. Writes take effect on the clock edge. Reads are combinational.

Top module: `cap_timer`

## Requirements
- R1: After reset, every register reads 0: control, counter, compare, capture, and the status byte.
- R2: The control register sits at address 0. Its bits are: 7 = 16-bit width, 6 = capture enable, 5 = filter enable, 4 = edge select (1 rising, 0 falling), 3 = capture source (0 selects `cap_src0`, 1 selects `cap_src1`), 0 = clear-on-compare mode. Bits 2 and 1 always read 0, and writes to them have no effect (writing 0xFF reads back 0xF9).
- R3: In free-running mode the counter adds one every cycle. At 8-bit width only the low byte counts and wraps 0xFF to 0x00, and the high byte keeps its value. At 16-bit width the counter wraps 0xFFFF to 0x0000.
- R4: In clear-on-compare mode, when the active counter value equals the compare value, the counter is 0 on the next cycle. The compare value is address 3 at 8-bit width and {address 4, address 3} at 16-bit width.
- R5: With the filter off, a qualifying edge that is first present at the input before clock edge k copies the counter value held between edges k+1 and k+2 into the capture register at edge k+2. The capture register is read at address 5 (low byte) and address 6 (high byte), and its high byte is 0 at 8-bit width.
- R6: Only the edge direction chosen by control bit 4 triggers a capture.
- R7: Transitions on the capture input that control bit 3 does not select cause no capture.
- R8: With the filter on, the filtered level changes only after four consecutive synchronized samples agree. A pulse of three cycles or fewer is rejected, a four-cycle pulse passes, and capture happens four cycles later than with the filter off.
- R9: With control bit 6 at 0, no capture occurs: the capture register keeps its value and the flag stays clear.
- R10: The status byte is at address 7: bit 0 is the capture flag, bit 1 is the interrupt enable. A write with bit 0 set clears the flag, but a capture in the same cycle wins. A write sets the enable from bit 1. `cap_irq` equals flag AND enable.
- R11: `cmp_match` is high in exactly the cycles where the active counter value equals the active compare value, in either counting mode. Writes to address 1 or 2 load that counter byte and hold the other byte for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cap_src0 | input | 1 | Capture input, source 0 |
| cap_src1 | input | 1 | Capture input, source 1 |
| cap_irq | output | 1 | Capture interrupt request |
| cmp_match | output | 1 | High while the counter equals the compare value |

## Verification
A counter byte written at edge e reads back at the next sampling point and then rises by one per cycle. The bench therefore steps a reference model once per falling edge and compares the low byte and `cmp_match` at every sample. A capture input changed just before edge k is captured at edge k+2 without the filter and at edge k+6 with it. Each capture test loads a known counter value S at the edge just before the stimulus, so the expected capture value is S+2 or S+6, reduced to the active width. The capture register and flag are read only after that edge has passed. The same-cycle flag-clear case places the clearing write on exactly edge k+2.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cap_src0,
  input  logic       cap_src1,
  output logic       cap_irq,
  output logic       cmp_match
);
  localparam int BW = 8;
  localparam int CW = 2 * BW;
  localparam logic [7:0] CTRL_MASK = 8'hF9;

  logic [7:0]          ctrl;
  logic [CW-1:0]       cnt, cnt_nx, cmpv, capv;
  logic                flag, ie;
  logic                s1, s2, filt_q, lv_d;
  logic [FILT_LEN-2:0] hist;

  wire wide    = ctrl[7];
  wire cap_en  = ctrl[6];
  wire filt_en = ctrl[5];
  wire rise    = ctrl[4];
  wire src_sel = ctrl[3];
  wire ctc     = ctrl[0];

  wire ctrl_wr = reg_wr && reg_addr == 3'd0;
  wire lo_wr   = reg_wr && reg_addr == 3'd1;
  wire hi_wr   = reg_wr && reg_addr == 3'd2;
  wire cnt_wr  = lo_wr || hi_wr;
  wire stat_wr = reg_wr && reg_addr == 3'd7;

  wire [CW-1:0] cnt_v = wide ? cnt  : {{BW{1'b0}}, cnt[BW-1:0]};
  wire [CW-1:0] top_v = wide ? cmpv : {{BW{1'b0}}, cmpv[BW-1:0]};
  assign cmp_match = (cnt_v == top_v);

  wire raw     = src_sel ? cap_src1 : cap_src0;
  wire agree   = (&{hist, s2}) || !(|{hist, s2});
  wire lv      = filt_en ? filt_q : s2;
  wire cap_evt = cap_en && (lv != lv_d) && (lv == rise);

  assign cap_irq = flag && ie;

  always_comb begin
    if (ctc && cmp_match)
      cnt_nx = wide ? '0 : {cnt[CW-1:BW], {BW{1'b0}}};
    else if (wide)
      cnt_nx = cnt + 1'b1;
    else
      cnt_nx = {cnt[CW-1:BW], cnt[BW-1:0] + 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      cnt  <= '0;
      cmpv <= '0;
    end else begin
      if (ctrl_wr) ctrl <= reg_wdata & CTRL_MASK;
      if (lo_wr)      cnt <= {cnt[CW-1:BW], reg_wdata};
      else if (hi_wr) cnt <= {reg_wdata, cnt[BW-1:0]};
      else            cnt <= cnt_nx;
      if (reg_wr && reg_addr == 3'd3) cmpv[BW-1:0]  <= reg_wdata;
      if (reg_wr && reg_addr == 3'd4) cmpv[CW-1:BW] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; hist <= '0;
      filt_q <= 1'b0; lv_d <= 1'b0;
    end else begin
      s1   <= raw;
      s2   <= s1;
      hist <= {hist[FILT_LEN-3:0], s2};
      if (agree) filt_q <= s2;
      lv_d <= lv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capv <= '0; flag <= 1'b0; ie <= 1'b0;
    end else begin
      if (cap_evt) capv <= cnt_v;
      if (cap_evt) flag <= 1'b1;
      else if (stat_wr && reg_wdata[0]) flag <= 1'b0;
      if (stat_wr) ie <= reg_wdata[1];
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = ctrl;
      3'd1: reg_rdata = cnt[BW-1:0];
      3'd2: reg_rdata = cnt[CW-1:BW];
      3'd3: reg_rdata = cmpv[BW-1:0];
      3'd4: reg_rdata = cmpv[CW-1:BW];
      3'd5: reg_rdata = capv[BW-1:0];
      3'd6: reg_rdata = capv[CW-1:BW];
      default: reg_rdata = {6'b0, ie, flag};
    endcase
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[2:1] == 2'b00);

  p_ctc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc && cmp_match && !cnt_wr && !ctrl_wr) |=> (cnt_v == '0));

  p_cap_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (capv == $past(cnt_v)));

  p_filter_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !agree |=> (filt_q == $past(filt_q)));

  p_cap_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(capv));

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag);
endmodule

// File: tb/cap_timer_tb.sv
`timescale 1ns/1ps
module cap_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cap_src0 = 1'b0, cap_src1 = 1'b0;
  logic       cap_irq, cmp_match;
  int n_cmp = 0, n_err = 0;

  always #2 clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_src0(cap_src0),
    .cap_src1(cap_src1), .cap_irq(cap_irq), .cmp_match(cmp_match));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
    @(negedge clk);
  endtask

  task automatic run(input bit wide, input bit ctc, input logic [15:0] top,
                     input logic [15:0] start, input int n);
    logic [15:0] v, tv, tt;
    wr(3'd0, {wide, 6'b0, ctc});
    wr(3'd3, top[7:0]);
    wr(3'd4, top[15:8]);
    wr(3'd2, start[15:8]);
    wr(3'd1, start[7:0]);
    v = start;
    reg_addr = 3'd1;
    #0.5;
    for (int i = 0; i < n; i++) begin
      tv = wide ? v : {8'h00, v[7:0]};
      tt = wide ? top : {8'h00, top[7:0]};
      chk(ctc ? "R4 count low byte" : "R3 count low byte", reg_rdata, v[7:0]);
      chk("R11 cmp_match", cmp_match, tv == tt);
      if (ctc && tv == tt) v = wide ? 16'h0 : {v[15:8], 8'h00};
      else if (wide)       v = v + 16'd1;
      else                 v = {v[15:8], v[7:0] + 8'd1};
      @(negedge clk);
      #0.5;
    end
    reg_addr = 3'd2;
    #0.5;
    chk(wide ? "R3 high byte 16-bit" : "R3 high byte held", reg_rdata, v[15:8]);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [7:0] r, lo, hi;
    logic [15:0] s, e;
    bit idle;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], r);
      chk($sformatf("R1 reset addr %0d", a), r, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    wr(3'd0, 8'hFF);
    rd(3'd0, r);
    chk("R2 reserved bits read zero", r, 8'hF9);
    wr(3'd0, 8'h00);

    run(1'b0, 1'b0, 16'h0000, 16'h33FD, 6);
    run(1'b1, 1'b0, 16'h0000, 16'hFFFD, 6);
    run(1'b1, 1'b0, 16'h1234, 16'h1231, 6);
    run(1'b0, 1'b1, 16'hAA00, 16'h0000, 8);
    run(1'b0, 1'b1, 16'hAA03, 16'h0000, 12);
    run(1'b0, 1'b1, 16'h5507, 16'h0000, 20);
    run(1'b0, 1'b1, 16'h0004, 16'h00FA, 16);
    run(1'b1, 1'b1, 16'h0102, 16'h00FE, 12);
    run(1'b1, 1'b1, 16'h0000, 16'h0000, 5);

    // capture sweep: width x filter x edge x source
    for (int c = 0; c < 16; c++) begin
      bit wide, filt, rise, src;
      wide = c[0]; filt = c[1]; rise = c[2]; src = c[3];
      idle = !rise;
      wr(3'd0, {wide, 1'b1, filt, rise, src, 3'b000});
      cap_src0 = idle; cap_src1 = idle;
      repeat (10) @(negedge clk);
      wr(3'd7, 8'h03);
      if (src) cap_src0 = !idle; else cap_src1 = !idle;
      repeat (10) @(negedge clk);
      rd(3'd7, r);
      chk("R7 unselected source ignored", r, 8'h02);
      s = 16'h12FE;
      wr(3'd2, s[15:8]);
      wr(3'd1, s[7:0]);
      if (src) cap_src1 = !idle; else cap_src0 = !idle;
      repeat (filt ? 8 : 4) @(negedge clk);
      e = s + (filt ? 16'd6 : 16'd2);
      if (!wide) e = {8'h00, e[7:0]};
      rd(3'd5, lo);
      rd(3'd6, hi);
      chk($sformatf("%s capture value combo %0d", filt ? "R8" : "R5", c), {hi, lo}, e);
      rd(3'd7, r);
      chk($sformatf("R6 edge flag combo %0d", c), r, 8'h03);
      chk("R10 irq raised", cap_irq, 1);
      // opposite edge must not capture
      wr(3'd7, 8'h03);
      if (src) cap_src1 = idle; else cap_src0 = idle;
      repeat (10) @(negedge clk);
      rd(3'd7, r);
      chk($sformatf("R6 opposite edge ignored combo %0d", c), r, 8'h02);
    end

    // filter pulse widths, rising edge, source 0
    wr(3'd0, 8'h70);
    cap_src0 = 1'b0; cap_src1 = 1'b0;
    repeat (10) @(negedge clk);
    wr(3'd7, 8'h03);
    for (int w = 1; w <= 4; w++) begin
      cap_src0 = 1'b1;
      repeat (w) @(negedge clk);
      cap_src0 = 1'b0;
      repeat (12) @(negedge clk);
      rd(3'd7, r);
      chk($sformatf("R8 pulse width %0d", w), r[0], w >= 4);
      wr(3'd7, 8'h03);
    end
    // one-cycle pulse passes without the filter
    wr(3'd0, 8'h50);
    repeat (4) @(negedge clk);
    wr(3'd7, 8'h03);
    cap_src0 = 1'b1;
    @(negedge clk);
    cap_src0 = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd7, r);
    chk("R5 unfiltered single-cycle pulse", r[0], 1);

    // capture disabled
    rd(3'd5, lo);
    wr(3'd0, 8'h10);
    wr(3'd7, 8'h03);
    cap_src0 = 1'b1;
    repeat (10) @(negedge clk);
    rd(3'd5, r);
    chk("R9 capture register unchanged", r, lo);
    rd(3'd7, r);
    chk("R9 flag stays clear", r, 8'h02);
    cap_src0 = 1'b0;

    // clear vs capture priority
    wr(3'd0, 8'h50);
    repeat (6) @(negedge clk);
    wr(3'd7, 8'h03);
    cap_src0 = 1'b1;
    repeat (4) @(negedge clk);
    cap_src0 = 1'b0;
    repeat (4) @(negedge clk);
    cap_src0 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(3'd7, 8'h01);
    rd(3'd7, r);
    chk("R10 capture wins over clear", r, 8'h01);
    chk("R10 irq masked when disabled", cap_irq, 0);
    wr(3'd7, 8'h01);
    rd(3'd7, r);
    chk("R10 write-one clears flag", r, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule